// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Claim and Complete

This block gathers a parameterised set of external interrupt sources and presents them to a few processor contexts through a 32-bit memory-mapped register space. Software assigns each source a 3-bit priority. Each context has its own enable vector and its own priority threshold. The block raises one request line per context while that context has work waiting.

A handler reads its context's claim register. The read returns the identifier of the best waiting source and takes that source out of the pending set. When the handler has finished, it writes the same identifier back to the register. Between the claim and the completion the source is held in flight, so it cannot request again.

Each source passes through a small gateway state machine with three states. GW_IDLE means no request is held. GW_PEND means a request waits for a claim. GW_BUSY means the source has been claimed and is waiting for completion. The transitions are:

- *request*: GW_IDLE to GW_PEND.
- *claim*: GW_PEND to GW_BUSY.
- *complete*: GW_BUSY to GW_IDLE.
- *complete with replay*: GW_BUSY to GW_PEND. This is taken only by edge-mode sources that saw a rising edge while busy.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Identifier 0 is not a source. Its priority word reads 0, bit 0 of every enable word reads 0, and it is never claimed. A claim read that returns 0 means nothing is eligible.
- R2: Address map (byte addresses, word access):
  - The priority of source n is at 4*n, held in bits [2:0].
  - The enable block of context c starts at 0x2000 + 0x80*c. Source n is bit (n mod 32) of word n/32 of that block.
  - The threshold of context c is at 0x200000 + 0x1000*c, in bits [2:0].
  - The claim/complete register of context c is at that threshold address plus 4.
  - Written values read back.
- R3: A source is eligible for a context only when all three hold: it is pending, it is enabled for that context, and its priority is strictly greater than the context threshold. Priority 0 never qualifies, and threshold 7 masks the context.
- R4: `ctx_irq[c]` is high exactly while some source is eligible for context c. It falls in the cycle after a claim that leaves none eligible.
- R5: A claim read returns the eligible source of highest priority, with ties going to the lowest identifier. The value appears on `bus_rdata` in the cycle after the request. The same access clears that source's pending state and puts it in flight.
- R6: A completion write of identifier n to context c ends the flight of n only if n is enabled for context c and n is in flight. Any other completion write changes nothing.
- R7: A level-mode source becomes pending while its input is high and it is idle. It never becomes pending while in flight. After completion it pends again only if its input is still high.
- R8: An edge-mode source (a set bit in `EDGE_SRC`, by default the highest identifier) pends on a rising input. A rising edge seen while in flight is remembered and makes the source pending again right after completion. Without such an edge, the source returns to idle.
- R9: Reads from unmapped addresses return 0, and writes to them change no register.
- R10: After reset all priorities, enables and thresholds are 0, no source is pending and every `ctx_irq` bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| src_irq | input | NSRC | Interrupt inputs, bit n for source n (bit 0 unused) |
| ctx_irq | output | NCTX | Interrupt request per context |

## Verification
The hardest situations to reach from the ports involve a source that is in flight. One is a rising edge arriving while an edge-mode source is busy, which must be replayed only after completion. The other is a completion written through a context that has the source disabled, which must leave the source busy. The stimulus reaches both by keeping level inputs high across claims, so that a wrongly accepted completion would show up at once as a renewed claim result. It also pulses the edge source once while it is busy and then completes it twice. A further sequence walks the threshold through equal and above-equal values against a pending source, to expose a non-strict compare.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int PRIO_W = 3;
    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic [1:0] {
        GW_IDLE = 2'd0,
        GW_PEND = 2'd1,
        GW_BUSY = 2'd2
    } gw_state_e;

    localparam logic [31:0] EN_BASE    = 32'h0000_2000;
    localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
    localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
    localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;

endpackage

// File: rtl/irq_gateway.sv
module irq_gateway
    import irq_ctrl_pkg::*;
#(
    parameter bit EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_in,
    input  logic claim,
    input  logic complete,
    output logic pend,
    output logic busy
);

    gw_state_e state_q, state_d;
    logic      prev_q;
    logic      seen_q;
    logic      rise;
    logic      trig;

    assign rise = src_in & ~prev_q;
    assign trig = EDGE ? rise : src_in;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GW_IDLE;
            prev_q  <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= src_in;
            if (state_q != GW_BUSY || complete)
                seen_q <= 1'b0;
            else if (rise)
                seen_q <= 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_IDLE: if (trig)  state_d = GW_PEND;
            GW_PEND: if (claim) state_d = GW_BUSY;
            GW_BUSY: if (complete)
                         state_d = (EDGE && (seen_q || rise)) ? GW_PEND : GW_IDLE;
            default: state_d = GW_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pend = (state_q == GW_PEND);
        busy = (state_q == GW_BUSY);
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_ctrl_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int ID_W = 4
) (
    input  logic [NSRC-1:0]        pend,
    input  logic [NSRC-1:0]        en,
    input  logic [NSRC*PRIO_W-1:0] prio_flat,
    input  prio_t                  thr,
    output logic [ID_W-1:0]        win_id,
    output logic                   any_req
);

    always_comb begin
        prio_t best_p;
        prio_t p;
        best_p  = '0;
        win_id  = '0;
        any_req = 1'b0;
        for (int i = 1; i < NSRC; i++) begin
            p = prio_flat[i*PRIO_W +: PRIO_W];
            if (pend[i] && en[i] && (p > thr)) begin
                any_req = 1'b1;
                if (p > best_p) begin
                    best_p = p;
                    win_id = ID_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int              NSRC     = 16,
    parameter int              NCTX     = 2,
    parameter int              ADDR_W   = 24,
    parameter logic [NSRC-1:0] EDGE_SRC = {1'b1, {(NSRC-1){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NSRC-1:0]   src_irq,
    output logic [NCTX-1:0]   ctx_irq
);

    localparam int ID_W  = (NSRC > 2) ? $clog2(NSRC) : 1;
    localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1;
    localparam int NWORD = (NSRC + 31) / 32;
    localparam int ENW   = NWORD * 32;
    localparam logic [31:0] PRIO_END = 32'(NSRC * 4);
    localparam logic [31:0] EN_END   = EN_BASE + 32'(NCTX) * EN_STRIDE;
    localparam logic [31:0] CTX_END  = CTX_BASE + 32'(NCTX) * CTX_STRIDE;

    prio_t             prio_q [NSRC];
    logic [NSRC-1:0]   en_q   [NCTX];
    prio_t             thr_q  [NCTX];
    logic [31:0]       rdata_q;

    logic [NSRC*PRIO_W-1:0] prio_flat;
    logic [NCTX*PRIO_W-1:0] thr_flat;
    logic [NSRC-1:0]   gw_pend, gw_busy, claim_vec, cmp_vec;
    logic [ID_W-1:0]   win_id [NCTX];
    logic [NCTX-1:0]   any_req;

    // ---------------- address decode ----------------
    logic [31:0]      a32, en_off, ctx_off;
    logic             prio_hit, en_hit, thr_sel, clm_sel;
    logic [ID_W-1:0]  prio_idx;
    logic [CTX_W-1:0] en_ctx, c_ctx;
    logic [4:0]       en_wd;
    logic             rd_claim, wr_claim;

    always_comb begin
        a32      = 32'(bus_addr);
        en_off   = a32 - EN_BASE;
        ctx_off  = a32 - CTX_BASE;
        prio_hit = (a32 < PRIO_END);
        prio_idx = ID_W'(a32 >> 2);
        en_wd    = en_off[6:2];
        en_ctx   = CTX_W'(en_off >> 7);
        en_hit   = (a32 >= EN_BASE) && (a32 < EN_END) &&
                   ({27'b0, en_wd} < 32'(NWORD));
        c_ctx    = CTX_W'(ctx_off >> 12);
        thr_sel  = (a32 >= CTX_BASE) && (a32 < CTX_END) && (ctx_off[11:0] == 12'h000);
        clm_sel  = (a32 >= CTX_BASE) && (a32 < CTX_END) && (ctx_off[11:0] == 12'h004);
        rd_claim = bus_req && !bus_we && clm_sel;
        wr_claim = bus_req &&  bus_we && clm_sel;
    end

    // ---------------- configuration registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
            for (int c = 0; c < NCTX; c++) begin
                en_q[c]  <= '0;
                thr_q[c] <= '0;
            end
        end else if (bus_req && bus_we) begin
            for (int i = 1; i < NSRC; i++)
                if (prio_hit && prio_idx == ID_W'(i))
                    prio_q[i] <= bus_wdata[PRIO_W-1:0];
            for (int c = 0; c < NCTX; c++) begin
                for (int i = 1; i < NSRC; i++)
                    if (en_hit && en_ctx == CTX_W'(c) && {27'b0, en_wd} == 32'(i / 32))
                        en_q[c][i] <= bus_wdata[i % 32];
                if (thr_sel && c_ctx == CTX_W'(c))
                    thr_q[c] <= bus_wdata[PRIO_W-1:0];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NSRC; i++) prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
        for (int c = 0; c < NCTX; c++) thr_flat[c*PRIO_W +: PRIO_W]  = thr_q[c];
    end

    // ---------------- claim / complete strobes ----------------
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            claim_vec[i] = rd_claim && (i != 0) && (win_id[c_ctx] == ID_W'(i));
            cmp_vec[i]   = wr_claim && (i != 0) && (bus_wdata == 32'(i)) && en_q[c_ctx][i];
        end
    end

    // ---------------- gateways ----------------
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        if (g == 0) begin : g_none
            assign gw_pend[g] = 1'b0;
            assign gw_busy[g] = 1'b0;
        end else begin : g_gw
            irq_gateway #(.EDGE(EDGE_SRC[g])) u_gw (
                .clk      (clk),
                .rst_n    (rst_n),
                .src_in   (src_irq[g]),
                .claim    (claim_vec[g]),
                .complete (cmp_vec[g]),
                .pend     (gw_pend[g]),
                .busy     (gw_busy[g])
            );
        end
    end

    // ---------------- per-context arbitration ----------------
    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        irq_arbiter #(.NSRC(NSRC), .ID_W(ID_W)) u_arb (
            .pend      (gw_pend),
            .en        (en_q[c]),
            .prio_flat (prio_flat),
            .thr       (thr_q[c]),
            .win_id    (win_id[c]),
            .any_req   (any_req[c])
        );
    end

    assign ctx_irq = any_req;

    // ---------------- read path ----------------
    logic [31:0] rd_val;
    always_comb begin
        logic [ENW-1:0] en_pad;
        rd_val = '0;
        en_pad = ENW'(en_q[en_ctx]);
        if (prio_hit) begin
            rd_val = 32'(prio_q[prio_idx]);
        end else if (en_hit) begin
            for (int w = 0; w < NWORD; w++)
                if ({27'b0, en_wd} == 32'(w)) rd_val = en_pad[32*w +: 32];
        end else if (thr_sel) begin
            rd_val = 32'(thr_q[c_ctx]);
        end else if (clm_sel) begin
            rd_val = 32'(win_id[c_ctx]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (bus_req && !bus_we)
            rdata_q <= rd_val;
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_ctrl_pkg::*;
#(
    parameter int NSRC   = 16,
    parameter int NCTX   = 2,
    parameter int ADDR_W = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_req,
    input logic                   bus_we,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [31:0]            bus_rdata,
    input logic [NCTX-1:0]        ctx_irq,
    input logic [NSRC-1:0]        gw_pend,
    input logic [NSRC-1:0]        gw_busy,
    input logic [NSRC-1:0]        claim_vec,
    input logic [NSRC-1:0]        cmp_vec,
    input logic [NCTX*PRIO_W-1:0] thr_flat
);

    // R1
    id0_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && 32'(bus_addr) == 32'h0) |=> (bus_rdata == 32'h0));

    // R1
    empty_claim_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && 32'(bus_addr) == CTX_BASE + 32'd4 && !ctx_irq[0])
        |=> (bus_rdata == 32'h0));

    // R5
    single_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_vec));

    for (genvar c = 0; c < NCTX; c++) begin : g_c
        // R3
        thr_max_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_flat[c*PRIO_W +: PRIO_W] == 3'd7) |-> !ctx_irq[c]);
    end

    for (genvar i = 1; i < NSRC; i++) begin : g_s
        // R5
        claim_to_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
            claim_vec[i] |=> (gw_busy[i] && !gw_pend[i]));
        // R7
        flight_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gw_busy[i] && !cmp_vec[i]) |=> (gw_busy[i] && !gw_pend[i]));
    end

endmodule

bind prio_irq_ctrl irq_ctrl_chk #(.NSRC(NSRC), .NCTX(NCTX), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .ctx_irq   (ctx_irq),
    .gw_pend   (gw_pend),
    .gw_busy   (gw_busy),
    .claim_vec (claim_vec),
    .cmp_vec   (cmp_vec),
    .thr_flat  (thr_flat)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;

    localparam int NSRC = 16;
    localparam int NCTX = 2;
    localparam int ADDR_W = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NSRC-1:0]   src_irq = '0;
    logic [NCTX-1:0]   ctx_irq;

    int nchk = 0;
    int nfail = 0;
    logic rd_flag = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    prio_irq_ctrl #(.NSRC(NSRC), .NCTX(NCTX), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_irq(src_irq), .ctx_irq(ctx_irq)
    );

    function automatic logic [31:0] a_prio(int n); return 32'(4 * n); endfunction
    function automatic logic [31:0] a_en(int c);   return 32'h2000 + 32'(c) * 32'h80; endfunction
    function automatic logic [31:0] a_thr(int c);  return 32'h200000 + 32'(c) * 32'h1000; endfunction
    function automatic logic [31:0] a_clm(int c);  return a_thr(c) + 32'd4; endfunction

    // monitor: compares each read result in the cycle after its request
    always @(posedge clk) rd_flag <= bus_req && !bus_we;
    always @(negedge clk) begin
        if (rd_flag) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            nchk++;
            if (bus_rdata !== e) begin
                nfail++;
                $display("FAIL %s: rdata actual %0h expected %0h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a[ADDR_W-1:0]; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a[ADDR_W-1:0];
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic chk_irq(input logic [NCTX-1:0] e, input string t);
        @(negedge clk);
        nchk++;
        if (ctx_irq !== e) begin
            nfail++;
            $display("FAIL %s: ctx_irq actual %b expected %b", t, ctx_irq, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse15();
        @(negedge clk); src_irq[15] = 1'b1;
        @(negedge clk); src_irq[15] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10 reset state
        chk_irq(2'b00, "R10 irq after reset");
        rd(a_prio(3), 0, "R10 prio reset");
        rd(a_thr(1),  0, "R10 thr reset");
        rd(a_en(0),   0, "R10 enable reset");
        rd(a_clm(0),  0, "R10 claim empty");

        // R1 identifier 0 hardwired
        wr(a_prio(0), 5);
        rd(a_prio(0), 0, "R1 prio of id 0");
        wr(a_en(0), 32'hFFFF);
        rd(a_en(0), 32'hFFFE, "R1 enable bit 0");

        // R2 configuration
        wr(a_prio(3), 2); wr(a_prio(5), 4); wr(a_prio(7), 4);
        wr(a_en(1), 32'h0008);
        wr(a_thr(1), 1);
        rd(a_prio(3), 2, "R2 prio3 readback");
        rd(a_prio(5), 4, "R2 prio5 readback");
        rd(a_en(1), 32'h8, "R2 en1 readback");
        rd(a_thr(1), 1, "R2 thr1 readback");

        // R3/R4/R5 arbitration
        @(negedge clk); src_irq[3] = 1'b1; src_irq[5] = 1'b1; src_irq[7] = 1'b1;
        idle(2);
        chk_irq(2'b11, "R4 both contexts requested");
        rd(a_clm(0), 5, "R5 tie goes to lowest id");
        rd(a_clm(0), 7, "R5 next highest");
        rd(a_clm(0), 3, "R5 lowest priority last");
        chk_irq(2'b00, "R4 drop after last claim");
        rd(a_clm(0), 0, "R7 busy level sources stay quiet");

        // R7 level re-pend after completion
        wr(a_clm(0), 5);
        idle(2);
        rd(a_clm(0), 5, "R7 level re-pend");

        // R6 completion via non-enabled context ignored
        wr(a_clm(1), 7);
        idle(2);
        rd(a_clm(0), 0, "R6 completion on disabled ctx ignored");
        wr(a_clm(0), 7);
        idle(2);
        rd(a_clm(0), 7, "R6 completion accepted");
        wr(a_clm(1), 3);
        idle(2);
        chk_irq(2'b11, "R6 completion via ctx1 re-pends 3");

        // R3 threshold strictness and masking
        wr(a_thr(1), 2);
        chk_irq(2'b01, "R3 equal threshold blocks");
        wr(a_thr(0), 7);
        chk_irq(2'b00, "R3 threshold 7 masks");
        rd(a_thr(0), 7, "R2 thr0 readback");
        rd(a_clm(0), 0, "R3 masked claim empty");
        wr(a_thr(1), 1);
        chk_irq(2'b10, "R3 threshold below priority");
        rd(a_clm(1), 3, "R5 claim on ctx1");
        wr(a_thr(0), 0);

        // R3 priority 0 never interrupts
        @(negedge clk); src_irq[9] = 1'b1;
        idle(2);
        chk_irq(2'b00, "R3 priority 0 ignored");
        rd(a_clm(0), 0, "R3 priority 0 not claimed");

        // R7 no re-pend when input low at completion
        @(negedge clk); src_irq[5] = 1'b0;
        wr(a_clm(0), 5);
        idle(2);
        rd(a_clm(0), 0, "R7 low input stays idle");

        // R8 edge-mode source
        wr(a_prio(15), 6);
        pulse15();
        idle(1);
        chk_irq(2'b01, "R8 edge pends");
        rd(a_clm(0), 15, "R8 claim edge source");
        chk_irq(2'b00, "R4 drop after claim");
        pulse15();
        idle(1);
        rd(a_clm(0), 0, "R8 edge while busy held back");
        wr(a_clm(0), 15);
        idle(2);
        rd(a_clm(0), 15, "R8 latched edge replayed");
        wr(a_clm(0), 15);
        idle(2);
        rd(a_clm(0), 0, "R8 no edge returns idle");

        // R9 unmapped space
        rd(a_prio(16), 0, "R9 priority beyond sources");
        rd(32'h3000, 0, "R9 gap read");
        wr(32'h2100, 32'hFFFF);
        rd(a_en(1), 32'h8, "R9 write to absent ctx enable ignored");
        wr(32'h200008, 5);
        rd(a_thr(0), 0, "R9 write to unused ctx offset ignored");
        rd(32'h200008, 0, "R9 unused ctx offset reads 0");

        idle(3);
        if (exp_q.size() != 0) begin
            nfail++;
            $display("FAIL scoreboard: pending actual %0d expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule